// File: doc/BRIEF.md
# Maskable Interrupt Admission Gate

This block sits next to a processor's instruction sequencer and answers one question at every instruction boundary: should a new exception sequence begin, and of which kind? It watches the level-sensitive, active-low maskable request line, the current interrupt-disable flag and a code naming the flag-changing instruction that has just retired. From these it raises at most one single-cycle "take" pulse toward the sequencer. Non-maskable, software-break and reset requests pass through whatever the flag says.

The block's main job is timing the mask. For the maskable line, the mask applied at a boundary is the flag value held *before* the instruction that just retired. A clear done by the clear-mask instruction or by a status pull therefore admits a waiting request one boundary late. A return-from-interrupt is the exception: it restores the flag and the gate uses that restored value at once. Each admitted exception also asks the sequencer to set the flag, and the gate counts its own lagged mask as set from that point on.

Top module: `irq_gate`

## Requirements
- R1: While `rst_n` is low, every take output and `set_mask` stay 0. The lagged mask comes out of reset set, so at the first boundary after reset a low `irq_n` is not admitted, even with `mask_flag` at 0 and `flag_op` at 0.
- R2: All outputs are 0 in any cycle where `boundary` is 0.
- R3: At a boundary, `take_irq` is 1 exactly when `irq_n` is low, the effective mask is 0 and no higher-ranked request is present. A line that returns high before the boundary is not admitted.
- R4: When `flag_op` is 1 (return from interrupt), the effective mask is the current `mask_flag`. A restored 0 with `irq_n` low admits the request at that same boundary.
- R5: For `flag_op` 2 (clear mask), 4 (status pull) and 0 (no flag change), the effective mask is the `mask_flag` sampled at the previous boundary. A clear with `irq_n` held low is admitted at the next boundary, not the current one.
- R6: For `flag_op` 3 (set mask), the lagged rule also applies. If the flag was 0 before the set, a low `irq_n` is still admitted at the boundary where the set retires.
- R7: Whenever any take output is 1, `set_mask` is 1. The lagged mask then counts as 1 for the next boundary, whatever `mask_flag` reads.
- R8: `take_nmi`, `take_brk` and `take_rst` do not depend on `mask_flag` or on the lagged mask.
- R9: Priority is reset, then non-maskable, then break, then maskable. At most one take output is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| irq_n | input | 1 | Active-low maskable request line, level-sensitive |
| mask_flag | input | 1 | Current interrupt-disable flag |
| flag_op | input | 3 | Flag-changing instruction that retired: 0 none, 1 return, 2 clear, 3 set, 4 pull |
| nmi_req | input | 1 | Non-maskable request, already edge-detected |
| brk_req | input | 1 | Software break request |
| rst_req | input | 1 | Reset-sequence request |
| take_irq | output | 1 | Start maskable interrupt entry |
| take_nmi | output | 1 | Start non-maskable entry |
| take_brk | output | 1 | Start break entry |
| take_rst | output | 1 | Start reset entry |
| set_mask | output | 1 | Ask the sequencer to set the interrupt-disable flag |

## Verification
The assertions assume that `irq_n` is already synchronous to `clk`. They also assume that `flag_op` and `mask_flag` are valid and steady in any cycle where `boundary` is high, and that `flag_op` holds one of the five listed codes. The stimulus changes inputs only on the falling clock edge and draws `flag_op` only from those five codes. It mixes directed mask-timing sequences with random cycles, in which the request lines are sparse enough to leave room for maskable admissions.

// File: rtl/irq_gate_pkg.sv
// Package: shared encodings for the interrupt admission gate.
// Assumes: flag_op carries one of the listed codes at a boundary.
package irq_gate_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        FOP_NONE  = 3'd0,
        FOP_RET   = 3'd1,
        FOP_CLEAR = 3'd2,
        FOP_SET   = 3'd3,
        FOP_PULL  = 3'd4
    } flag_op_e;

    localparam int N_KINDS = 4;
    // Index order of the take vector, highest rank first.
    localparam int K_RST = 0;
    localparam int K_NMI = 1;
    localparam int K_BRK = 2;
    localparam int K_IRQ = 3;
endpackage

// File: rtl/irq_mask_track.sv
// Module: keeps the mask value as it stood one instruction ago and forms
// the effective mask for the maskable line.
// Assumes: mask_flag and op are stable while boundary is high.
module irq_mask_track
    import irq_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     boundary,
    input  logic     mask_flag,
    input  flag_op_e op,
    input  logic     entering,
    output logic     lag_mask,
    output logic     eff_mask
);
    logic lag_q;

    // Capture the post-instruction flag at each boundary, or force it set on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lag_q <= 1'b1;
        else if (boundary)
            lag_q <= entering ? 1'b1 : mask_flag;
    end

    // Return-from-interrupt uses the restored flag at once; all else lags.
    always_comb begin
        eff_mask = (op == FOP_RET) ? mask_flag : lag_q;
    end

    assign lag_mask = lag_q;

    // R7: after an admitted entry the lagged mask is set
    a_r7_entry_sets_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && entering) |=> lag_q);
endmodule

// File: rtl/irq_take_arb.sv
// Module: ranks the four entry kinds and emits at most one take pulse.
// Assumes: the caller qualifies requests with the boundary strobe.
module irq_take_arb
    import irq_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_KINDS-1:0] req,
    output logic [N_KINDS-1:0] grant
);
    // Grant the lowest-index (highest-rank) request only.
    always_comb begin
        grant = '0;
        for (int k = 0; k < N_KINDS; k++) begin
            if (req[k] && grant == '0)
                grant[k] = 1'b1;
        end
    end

    // R9: never more than one grant
    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R9: a reset request always wins
    a_r9_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req[K_RST] |-> grant[K_RST]);
endmodule

// File: rtl/irq_gate.sv
// Module: top of the interrupt admission gate. It decides at each instruction
// boundary which entry sequence, if any, the sequencer must start.
// Assumes: irq_n is synchronous to clk; boundary is a one-cycle strobe.
module irq_gate
    import irq_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic       irq_n,
    input  logic       mask_flag,
    input  logic [2:0] flag_op,
    input  logic       nmi_req,
    input  logic       brk_req,
    input  logic       rst_req,
    output logic       take_irq,
    output logic       take_nmi,
    output logic       take_brk,
    output logic       take_rst,
    output logic       set_mask
);
    flag_op_e           op;
    logic               lag_mask;
    logic               eff_mask;
    logic               entering;
    logic [N_KINDS-1:0] req;
    logic [N_KINDS-1:0] grant;

    assign op = flag_op_e'(flag_op);

    irq_mask_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .mask_flag (mask_flag),
        .op        (op),
        .entering  (entering),
        .lag_mask  (lag_mask),
        .eff_mask  (eff_mask)
    );

    // Qualify each request with the boundary strobe and reset.
    always_comb begin
        req        = '0;
        req[K_RST] = rst_req;
        req[K_NMI] = nmi_req;
        req[K_BRK] = brk_req;
        req[K_IRQ] = !irq_n && !eff_mask;
        if (!boundary || !rst_n)
            req = '0;
    end

    irq_take_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant)
    );

    assign take_rst = grant[K_RST];
    assign take_nmi = grant[K_NMI];
    assign take_brk = grant[K_BRK];
    assign take_irq = grant[K_IRQ];
    assign entering = |grant;
    assign set_mask = entering;

    // R2: nothing is taken away from a boundary
    a_r2_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |-> !set_mask);
    // R3: a maskable admission needs the line low
    a_r3_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !irq_n);
    // R5: a clear that is not a return cannot admit when the prior mask was set
    a_r5_clear_lags: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && op != FOP_RET && lag_mask) |-> !take_irq);
    // R8: a non-maskable request with no reset request is always taken
    a_r8_nmi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && nmi_req && !rst_req) |-> take_nmi);
endmodule

// File: tb/irq_gate_test.sv
module irq_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boundary = 1'b0, irq_n = 1'b1, mask_flag = 1'b1;
    logic [2:0] flag_op = 3'd0;
    logic       nmi_req = 1'b0, brk_req = 1'b0, rst_req = 1'b0;
    logic       take_irq, take_nmi, take_brk, take_rst, set_mask;

    int checks = 0;
    int failures = 0;
    int model_lag = 1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_gate uut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_n(irq_n),
        .mask_flag(mask_flag), .flag_op(flag_op), .nmi_req(nmi_req),
        .brk_req(brk_req), .rst_req(rst_req), .take_irq(take_irq),
        .take_nmi(take_nmi), .take_brk(take_brk), .take_rst(take_rst),
        .set_mask(set_mask)
    );

    task automatic cmp(input logic act, input logic exp, input string what, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive on falling edge, compare against the model, then advance the model.
    task automatic step(input logic b, input logic irqn, input logic mf, input logic [2:0] op,
                        input logic nmi, input logic brk, input logic rq, input string tag);
        int eff;
        logic e_rst, e_nmi, e_brk, e_irq;
        @(negedge clk);
        boundary = b; irq_n = irqn; mask_flag = mf; flag_op = op;
        nmi_req = nmi; brk_req = brk; rst_req = rq;
        #3;
        eff = (op == 3'd1) ? int'(mf) : model_lag;
        e_rst = 0; e_nmi = 0; e_brk = 0; e_irq = 0;
        if (b && rst_n) begin
            if (rq) e_rst = 1;
            else if (nmi) e_nmi = 1;
            else if (brk) e_brk = 1;
            else if (!irqn && eff == 0) e_irq = 1;
        end
        cmp(take_rst, e_rst, "take_rst", tag);
        cmp(take_nmi, e_nmi, "take_nmi", tag);
        cmp(take_brk, e_brk, "take_brk", tag);
        cmp(take_irq, e_irq, "take_irq", tag);
        cmp(set_mask, e_rst | e_nmi | e_brk | e_irq, "set_mask", tag);
        if (!rst_n) model_lag = 1;
        else if (b) model_lag = (e_rst | e_nmi | e_brk | e_irq) ? 1 : int'(mf);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        // R1: outputs quiet during reset, even with requests at a boundary
        step(1, 0, 0, 0, 1, 1, 1, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        rst_n = 1'b1;
        // R1: first boundary after reset holds the line off
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        // R3: now the lagged mask is 0 and the line is low
        step(1, 0, 0, 0, 0, 0, 0, "R3");
        // R7: the lagged mask was forced set, so no admission here
        step(1, 0, 0, 0, 0, 0, 0, "R7");
        // R2: line low between boundaries produces nothing
        step(0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, 0, 0, "R3");
        // R3: line high at the boundary is not admitted
        step(1, 1, 0, 0, 0, 0, 0, "R3");
        step(1, 1, 1, 3'd3, 0, 0, 0, "R6");
        // R5: clear with line low, taken one boundary later
        step(1, 0, 0, 3'd2, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 1, 0, 0, 0, 0, "R5");
        // R5: status pull clearing behaves the same
        step(1, 0, 0, 3'd4, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, 0, "R5");
        // R4: inside handler the lag is set; return restores 0 -> taken now
        step(1, 0, 0, 3'd1, 0, 0, 0, "R4");
        step(1, 1, 1, 0, 0, 0, 0, "R4");
        // R4: return restoring 1 blocks the line
        step(1, 0, 1, 3'd1, 0, 0, 0, "R4");
        // R6: flag 0 before a set; the set boundary still admits
        step(1, 1, 0, 0, 0, 0, 0, "R6");
        step(1, 0, 1, 3'd3, 0, 0, 0, "R6");
        step(1, 0, 1, 0, 0, 0, 0, "R6");
        // R8: unmasked kinds with flag set
        step(1, 1, 1, 0, 1, 0, 0, "R8");
        step(1, 1, 1, 0, 0, 1, 0, "R8");
        step(1, 1, 1, 0, 0, 0, 1, "R8");
        // R9: priority ladder
        step(1, 1, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 1, "R9");
        step(1, 1, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 0, "R9");
        step(1, 1, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 1, 0, "R9");
        // R3: mixed random cycles
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            int pick = $urandom_range(0, 4);
            op = 3'(pick);
            step(($urandom_range(0, 2) != 0), ($urandom_range(0, 2) == 0), $urandom_range(0, 1) != 0, op,
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 19) == 0), "R3");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule